// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block owns the program counter and the fetch/decode pipeline register of a five-stage integer pipeline. It settles conditional branches and jumps in the decode stage. Every cycle it presents a fetch address and captures the returned 32-bit instruction word into the fetch/decode register, together with that word's incremented address. It then steps the program counter by one instruction (4 bytes, because memory is byte addressed).

Fetch always runs ahead under the assumption that no branch is taken. When the instruction in decode is a branch, the block compares the two register values read for it. It adds the sign-extended, word-scaled 16-bit offset to the branch's incremented address. If the branch condition holds, or the instruction is a jump, it redirects fetch and raises `flush`. It also replaces the single wrong-path word that was fetched in the same cycle with an invalid all-zero slot, which acts as a no-op that writes nothing. A taken redirect therefore costs one bubble. A branch that is not taken costs none.

A stall input freezes the program counter and the fetch/decode register. A branch waiting in decode is not resolved until the stall is released.

Top module: `decode_branch_unit`

## Requirements
- R1: While reset is held and right after it is released, `fetchAddr` equals RESET_PC (default 0), `ifidValid` is 0 and `flush` is 0.
- R2: In a cycle with no stall and no redirect, the next edge adds 4 to `fetchAddr`. The same edge loads `fetchWord` into `ifidInstr`, sets `ifidValid` to 1, and loads the old fetch address plus 4 into `ifidPcNext`.
- R3: A valid decode instruction with opcode bits [31:26] = 6'd4 (branch-if-equal) is taken exactly when `rsVal` equals `rtVal`. Its target is `ifidPcNext` plus the sign-extended field [15:0] shifted left by 2.
- R4: A valid decode instruction with opcode 6'd5 (branch-if-not-equal) is taken exactly when `rsVal` differs from `rtVal`, and it uses the same target rule as R3.
- R5: A branch that is not taken, or any opcode other than 6'd2, 6'd4 and 6'd5 (even with equal operands), leaves `flush` low. Fetch continues sequentially and the following word enters decode as valid, with no lost cycle.
- R6: A taken redirect raises `flush` in the same cycle the instruction sits in decode. On the next edge, `fetchAddr` becomes the target and `ifidValid` and `ifidInstr` become 0. The word fetched at the target enters decode one edge after that.
- R7: A valid decode instruction with opcode 6'd2 (jump) always redirects. Its target is {`ifidPcNext`[31:28], field [25:0], 2'b00}.
- R8: While `stall` is 1, `fetchAddr`, `ifidInstr`, `ifidPcNext` and `ifidValid` hold and `flush` stays 0. A branch held in decode is resolved in the first cycle after `stall` drops.
- R9: A negative offset is sign-extended, so the branch target lies below the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Freeze the PC and the fetch/decode register |
| fetchWord | input | 32 | Instruction word read at `fetchAddr` |
| rsVal | input | DATA_W | First register value read for the decode instruction |
| rtVal | input | DATA_W | Second register value read for the decode instruction |
| fetchAddr | output | PC_W | Current fetch address (the PC) |
| ifidInstr | output | 32 | Instruction held in decode |
| ifidPcNext | output | PC_W | Address of the decode instruction plus 4 |
| ifidValid | output | 1 | Decode slot holds a real instruction |
| flush | output | 1 | Redirect taken this cycle; squash the fetched word |

## Verification
`flush` is combinational. It is due in the same cycle as the register values for the decode instruction, and the bench samples it a moment after driving them. The fetch address and the fetch/decode contents change one rising edge after the cycle that caused the change. After a taken redirect, the first valid target word appears in decode two edges after the redirect cycle. The bench drives inputs shortly after each rising edge and reads all results before the next edge. It keeps its own running model of the expected PC, so every target is checked against values computed from the encoding rules in the requirements.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int OFF_W   = 16;
  localparam int IDX_W   = 26;

  localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;
  localparam logic [OPC_W-1:0] OPC_BREQ = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BRNE = 6'd5;

  typedef enum logic [1:0] {
    TGT_SEQ    = 2'd0,
    TGT_BRANCH = 2'd1,
    TGT_JUMP   = 2'd2
  } tgtSel_e;

  typedef struct packed {
    logic    hold;
    logic    redirect;
    tgtSel_e tgtSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/bru_datapath.sv
module bru_datapath
  import bru_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int DATA_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [INSTR_W-1:0]   fetchWord,
  input  logic [DATA_W-1:0]    rsVal,
  input  logic [DATA_W-1:0]    rtVal,
  output logic [PC_W-1:0]      pcQ,
  output logic [INSTR_W-1:0]   ifidInstr,
  output logic [PC_W-1:0]      ifidPcNext,
  output logic                 ifidValid,
  output logic                 opsEqual
);
  localparam logic [PC_W-1:0] INSTR_BYTES = PC_W'(4);
  localparam int SEXT_W = PC_W - OFF_W - 2;
  localparam int JHI_W  = PC_W - IDX_W - 2;

  logic [PC_W-1:0] pcPlus4;
  logic [PC_W-1:0] brOffset;
  logic [PC_W-1:0] brTarget;
  logic [PC_W-1:0] jmpTarget;
  logic [PC_W-1:0] nextPc;

  // Operand compare runs beside decode; register fields need no decoding here.
  assign opsEqual  = (rsVal == rtVal);
  assign pcPlus4   = pcQ + INSTR_BYTES;
  assign brOffset  = {{SEXT_W{ifidInstr[OFF_W-1]}}, ifidInstr[OFF_W-1:0], 2'b00};
  assign brTarget  = ifidPcNext + brOffset;
  assign jmpTarget = {ifidPcNext[PC_W-1 -: JHI_W], ifidInstr[IDX_W-1:0], 2'b00};

  always_comb begin
    nextPc = pcPlus4;
    if (strobes.redirect) begin
      case (strobes.tgtSel)
        TGT_JUMP: nextPc = jmpTarget;
        default:  nextPc = brTarget;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ        <= RESET_PC;
      ifidInstr  <= '0;
      ifidPcNext <= '0;
      ifidValid  <= 1'b0;
    end else if (!strobes.hold) begin
      pcQ        <= nextPc;
      ifidPcNext <= pcPlus4;
      if (strobes.redirect) begin
        ifidInstr <= '0;
        ifidValid <= 1'b0;
      end else begin
        ifidInstr <= fetchWord;
        ifidValid <= 1'b1;
      end
    end
  end

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.hold && !strobes.redirect) |=> (pcQ == $past(pcQ) + INSTR_BYTES) && ifidValid);

  a_r6_squash_slot: assert property (@(posedge clk) disable iff (!rstN)
    strobes.redirect |=> (!ifidValid && ifidInstr == '0));

  a_r8_hold_state: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> ($stable(pcQ) && $stable(ifidInstr) && $stable(ifidValid) && $stable(ifidPcNext)));
endmodule

// File: rtl/bru_control.sv
module bru_control
  import bru_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             stall,
  input  logic [OPC_W-1:0] opcode,
  input  logic             ifidValid,
  input  logic             opsEqual,
  output ctrlStrobes_t     strobes,
  output logic             flush
);
  logic isBrEq;
  logic isBrNe;
  logic isJump;
  logic takeBr;
  logic takeJmp;

  assign isBrEq  = (opcode == OPC_BREQ);
  assign isBrNe  = (opcode == OPC_BRNE);
  assign isJump  = (opcode == OPC_JUMP);
  assign takeBr  = ifidValid && ((isBrEq && opsEqual) || (isBrNe && !opsEqual));
  assign takeJmp = ifidValid && isJump;

  always_comb begin
    strobes.hold     = stall;
    strobes.redirect = !stall && (takeBr || takeJmp);
    if (!strobes.redirect)
      strobes.tgtSel = TGT_SEQ;
    else if (takeJmp)
      strobes.tgtSel = TGT_JUMP;
    else
      strobes.tgtSel = TGT_BRANCH;
  end

  assign flush = strobes.redirect;

  a_r3_beq_needs_equal: assert property (@(posedge clk) disable iff (!rstN)
    (flush && opcode == OPC_BREQ) |-> opsEqual);

  a_r4_bne_needs_differ: assert property (@(posedge clk) disable iff (!rstN)
    (flush && opcode == OPC_BRNE) |-> !opsEqual);

  a_r7_jump_redirects: assert property (@(posedge clk) disable iff (!rstN)
    (ifidValid && opcode == OPC_JUMP && !stall) |-> flush);

  a_r8_stall_no_flush: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !flush);

  a_r5_flush_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> ifidValid);
endmodule

// File: rtl/decode_branch_unit.sv
module decode_branch_unit
  import bru_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int DATA_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic [INSTR_W-1:0] fetchWord,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic [DATA_W-1:0]  rtVal,
  output logic [PC_W-1:0]    fetchAddr,
  output logic [INSTR_W-1:0] ifidInstr,
  output logic [PC_W-1:0]    ifidPcNext,
  output logic               ifidValid,
  output logic               flush
);
  ctrlStrobes_t strobes;
  logic         opsEqual;

  bru_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .stall     (stall),
    .opcode    (ifidInstr[INSTR_W-1 -: OPC_W]),
    .ifidValid (ifidValid),
    .opsEqual  (opsEqual),
    .strobes   (strobes),
    .flush     (flush)
  );

  bru_datapath #(
    .PC_W     (PC_W),
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .fetchWord  (fetchWord),
    .rsVal      (rsVal),
    .rtVal      (rtVal),
    .pcQ        (fetchAddr),
    .ifidInstr  (ifidInstr),
    .ifidPcNext (ifidPcNext),
    .ifidValid  (ifidValid),
    .opsEqual   (opsEqual)
  );

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!ifidValid && !flush));
endmodule

// File: tb/sim_decode_branch_unit.sv
module sim_decode_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        stall;
  logic [31:0] fetchWord;
  logic [31:0] rsVal;
  logic [31:0] rtVal;
  logic [31:0] fetchAddr;
  logic [31:0] ifidInstr;
  logic [31:0] ifidPcNext;
  logic        ifidValid;
  logic        flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] expPc;

  decode_branch_unit u0 (
    .clk(clk), .rstN(rstN), .stall(stall), .fetchWord(fetchWord),
    .rsVal(rsVal), .rtVal(rtVal), .fetchAddr(fetchAddr), .ifidInstr(ifidInstr),
    .ifidPcNext(ifidPcNext), .ifidValid(ifidValid), .flush(flush)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic feed(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic st);
    fetchWord = w;
    rsVal     = a;
    rtVal     = b;
    stall     = st;
    #1;
  endtask

  function automatic logic [31:0] aluWord(int n);
    return {6'd0, 26'(n * 3 + 1)};
  endfunction

  function automatic logic [31:0] brWord(logic [5:0] opc, logic [15:0] off);
    return {opc, 5'd1, 5'd2, off};
  endfunction

  function automatic logic [31:0] brTgt(logic [31:0] pc4, logic [15:0] off);
    return pc4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  task automatic t_reset();
    rstN = 1'b0;
    feed(32'h0, 32'h0, 32'h0, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "fetchAddr in reset", fetchAddr, 32'h0);
    chk("R1", "ifidValid in reset", {31'h0, ifidValid}, 32'h0);
    #1 rstN = 1'b1;
    #1;
    chk("R1", "flush after reset", {31'h0, flush}, 32'h0);
    expPc = 32'h0;
  endtask

  task automatic t_sequential(int count);
    for (int i = 0; i < count; i++) begin
      feed(aluWord(i), 32'h0, 32'h0, 1'b0);
      chk("R2", "fetchAddr step", fetchAddr, expPc);
      tick();
      chk("R2", "ifidInstr capture", ifidInstr, aluWord(i));
      chk("R2", "ifidValid set", {31'h0, ifidValid}, 32'h1);
      chk("R2", "ifidPcNext", ifidPcNext, expPc + 32'd4);
      expPc += 32'd4;
    end
  endtask

  // Places word in decode, presents operands, checks resolution and recovery.
  task automatic t_decode(string req, logic [31:0] w, logic [31:0] a, logic [31:0] b,
                          bit taken, logic [31:0] tgt);
    logic [31:0] filler;
    filler = 32'h0000_ABCD;
    feed(w, 32'h0, 32'h0, 1'b0);
    chk(req, "fetchAddr before", fetchAddr, expPc);
    tick();
    expPc += 32'd4;
    chk(req, "decode holds word", ifidInstr, w);
    feed(filler, a, b, 1'b0);
    chk(req, "flush in decode cycle", {31'h0, flush}, {31'h0, taken});
    tick();
    if (taken) begin
      expPc = tgt;
      chk(req, "redirected fetchAddr", fetchAddr, expPc);
      chk("R6", "squashed valid", {31'h0, ifidValid}, 32'h0);
      chk("R6", "squashed instr", ifidInstr, 32'h0);
    end else begin
      expPc += 32'd4;
      chk("R5", "sequential fetchAddr", fetchAddr, expPc);
      chk("R5", "next word valid", {31'h0, ifidValid}, 32'h1);
      chk("R5", "next word kept", ifidInstr, filler);
    end
    feed(aluWord(9), 32'h0, 32'h0, 1'b0);
    chk(req, "no flush after", {31'h0, flush}, 32'h0);
    tick();
    chk("R6", "target word valid", {31'h0, ifidValid}, 32'h1);
    chk("R6", "target word pc", ifidPcNext, expPc + 32'd4);
    expPc += 32'd4;
  endtask

  task automatic t_stall_branch();
    logic [31:0] w;
    logic [31:0] pc4;
    w = brWord(6'd4, 16'd5);
    feed(w, 32'h0, 32'h0, 1'b0);
    tick();
    pc4 = expPc + 32'd4;
    expPc = pc4;
    for (int k = 0; k < 2; k++) begin
      feed(32'h1111_2222, 32'h7, 32'h7, 1'b1);
      chk("R8", "no flush while stalled", {31'h0, flush}, 32'h0);
      tick();
      chk("R8", "fetchAddr held", fetchAddr, pc4);
      chk("R8", "decode word held", ifidInstr, w);
      chk("R8", "decode valid held", {31'h0, ifidValid}, 32'h1);
      chk("R8", "decode pc held", ifidPcNext, pc4);
    end
    feed(32'h1111_2222, 32'h7, 32'h7, 1'b0);
    chk("R8", "flush after release", {31'h0, flush}, 32'h1);
    tick();
    expPc = brTgt(pc4, 16'd5);
    chk("R8", "redirect after release", fetchAddr, expPc);
    chk("R8", "squash after release", {31'h0, ifidValid}, 32'h0);
    feed(aluWord(4), 32'h0, 32'h0, 1'b0);
    tick();
    expPc += 32'd4;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequential(3);
    // R3: equal operands, positive offset
    t_decode("R3", brWord(6'd4, 16'd3), 32'h55, 32'h55, 1'b1, brTgt(expPc + 32'd4, 16'd3));
    // R3/R5: equal-branch with differing operands falls through
    t_decode("R3", brWord(6'd4, 16'd3), 32'h55, 32'h56, 1'b0, 32'h0);
    // R4 with R9: not-equal branch taken backwards
    t_decode("R4", brWord(6'd5, 16'hFFFE), 32'h1, 32'h2, 1'b1, brTgt(expPc + 32'd4, 16'hFFFE));
    // R9: larger backward step
    t_decode("R9", brWord(6'd5, 16'hFFF0), 32'h0, 32'h9, 1'b1, brTgt(expPc + 32'd4, 16'hFFF0));
    // R4/R5: not-equal branch with equal operands falls through
    t_decode("R4", brWord(6'd5, 16'd8), 32'hA, 32'hA, 1'b0, 32'h0);
    // R7: jump regardless of operands
    t_decode("R7", {6'd2, 26'h0000_040}, 32'h1, 32'h2, 1'b1,
             {expPc[31:28] + 4'h0, 26'h0000_040, 2'b00});
    // R5: non-branch opcode with equal operands never redirects
    t_decode("R5", {6'd7, 5'd1, 5'd2, 16'd4}, 32'h3, 32'h3, 1'b0, 32'h0);
    t_stall_branch();
    t_sequential(2);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule